// File: doc/BRIEF.md
# Triggered Capture Recorder with Pre-Trigger Window

This block records a data bus into an internal ring of `DEPTH` entries around a trigger event. After an arm pulse it stores one sample on every clock edge, wrapping round the ring. It accepts a trigger hit once enough samples have been gathered to fill the pre-trigger part of the window. It then stores a fixed number of further samples, stops, and raises `done`.

The window length and the pre-trigger share are sampled at the arm pulse and clamped to legal values. After capture, a combinational read port returns the window in time order. Index 0 is the oldest sample and index `size-1` is the newest. Trigger generation and the host bridge are outside this block.

Top module: `capture_window`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: `arm` high at a rising edge restarts capture from any state. In the next cycle `busy` is 1 and `done` is 0, and no sample is stored at that arm edge.
- R3: While `busy` is 1 and `arm` is 0, every rising edge stores `din` in the ring and advances the write position by one, modulo `DEPTH`. When `busy` is 0, nothing is stored.
- R4: A `hit` is ignored until at least `pre` samples have been stored since the arm edge. Edges after arming are numbered k = 1, 2, and so on. A hit is first accepted at the earliest edge k ≥ `pre`+1 at which `hit` is 1.
- R5: Counting the accepted hit edge, exactly `size − pre` samples are stored after the hit. In the cycle after the last of these edges, `done` is 1 and `busy` is 0.
- R6: `done` stays 1 until the next arm. While `done` is 1, `hit` and `din` change neither `done` nor the captured window.
- R7: `rd_data` shows, combinationally, the window sample at position `rd_idx`. Index 0 is the sample stored `pre` edges before the accepted hit. Index `size-1` is the last sample stored.
- R8: The effective `size` is the `win_size` value sampled at arm, with 0 treated as 1 and values above `DEPTH` treated as `DEPTH`.
- R9: The effective `pre` is `win_pre` sampled at arm, limited to `size − 1`.
- R10: The window reads back correctly when the write position has wrapped past the end of the ring one or more times before the hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| arm | input | 1 | Start or restart capture |
| hit | input | 1 | Trigger event from the trigger logic |
| din | input | DW | Sampled data bus |
| win_size | input | $clog2(DEPTH)+1 | Requested window length |
| win_pre | input | $clog2(DEPTH)+1 | Requested samples before the hit |
| rd_idx | input | $clog2(DEPTH) | Readout index, 0 is oldest |
| rd_data | output | DW | Captured sample at `rd_idx` |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Window complete |

## Verification
The assertions assume that `arm`, `hit` and `rst_n` are never unknown at a clock edge. They also assume that a restart may come at any time, so none of them relies on `arm` being a single-cycle pulse. The bench drives every input at the falling edge. It changes `win_size` and `win_pre` only in the cycle that carries `arm`, which keeps the clamped window fixed for the whole capture. Random window settings span the full port range, so both clamps are exercised, and random hit delays cover early hits, late hits and hits after wrap-around.

// File: rtl/capture_window.sv
module capture_window #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          hit,
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] win_size,
  input  logic [CW-1:0] win_pre,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_POST, S_DONE} state_t;

  state_t        state;
  logic [AW-1:0] wptr;
  logic [CW-1:0] fill, post_left, sz_q, pre_q;
  logic [CW-1:0] sz_c, pre_c;
  logic [DW-1:0] ring [DEPTH];
  logic          wr_en, accept;

  assign sz_c   = (win_size == '0) ? CW'(1) :
                  (win_size > CW'(DEPTH)) ? CW'(DEPTH) : win_size;
  assign pre_c  = (win_pre >= sz_c) ? sz_c - CW'(1) : win_pre;

  assign busy   = (state == S_FILL) || (state == S_POST);
  assign done   = (state == S_DONE);
  assign wr_en  = busy && !arm;
  assign accept = (state == S_FILL) && hit && (fill >= pre_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      wptr      <= '0;
      fill      <= '0;
      post_left <= '0;
      sz_q      <= CW'(1);
      pre_q     <= '0;
    end else if (arm) begin
      state <= S_FILL;
      fill  <= '0;
      sz_q  <= sz_c;
      pre_q <= pre_c;
    end else begin
      case (state)
        S_FILL: begin
          wptr <= wptr + AW'(1);
          if (fill != CW'(DEPTH)) fill <= fill + CW'(1);
          if (accept) begin
            post_left <= sz_q - pre_q - CW'(1);
            state     <= (sz_q - pre_q == CW'(1)) ? S_DONE : S_POST;
          end
        end
        S_POST: begin
          wptr      <= wptr + AW'(1);
          post_left <= post_left - CW'(1);
          if (post_left == CW'(1)) state <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) ring[wptr] <= din;
  end

  assign rd_data = ring[wptr - sz_q[AW-1:0] + rd_idx];

endmodule

module capture_window_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] wptr
);

  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r2_arm_starts: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (busy && !done));

  a_r3_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !arm) |=> (wptr == $past(wptr) + AW'(1)));

  a_r3_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || arm) |=> $stable(wptr));

  a_r5_done_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

endmodule

bind capture_window capture_window_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .busy(busy), .done(done), .wptr(wptr)
);

// File: tb/tb_capture_window.sv
module tb_capture_window;
  localparam int DW = 8, DEPTH = 16, AW = 4, CW = 5;

  logic clk = 0, rst_n = 0, arm = 0, hit = 0;
  logic [DW-1:0] din = '0;
  logic [CW-1:0] win_size = '0, win_pre = '0;
  logic [AW-1:0] rd_idx = '0;
  logic [DW-1:0] rd_data;
  logic busy, done;

  int vecs = 0, errs = 0;
  logic [DW-1:0] hist [256];

  always #2 clk = ~clk;

  capture_window #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hit(hit), .din(din),
    .win_size(win_size), .win_pre(win_pre), .rd_idx(rd_idx),
    .rd_data(rd_data), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp_size(input int s);
    if (s == 0) return 1;
    if (s > DEPTH) return DEPTH;
    return s;
  endfunction

  function automatic int clamp_pre(input int p, input int s);
    return (p >= s) ? s - 1 : p;
  endfunction

  task automatic capture(input int sz_in, input int pre_in, input int hstart, input string tag);
    int szc, prec, ka, klast, kdone;
    szc   = clamp_size(sz_in);
    prec  = clamp_pre(pre_in, szc);
    ka    = (hstart > prec + 1) ? hstart : prec + 1;
    klast = ka + (szc - prec) - 1;
    kdone = -1;
    @(negedge clk);
    win_size = CW'(sz_in); win_pre = CW'(pre_in); arm = 1; hit = 0;
    @(negedge clk);
    arm = 0;
    chk(busy && !done, {"R2 ", tag}, {busy, done}, 2);
    for (int k = 1; k <= klast + 3 && kdone < 0; k++) begin
      hist[k] = DW'($urandom);
      din = hist[k];
      hit = (k >= hstart);
      @(posedge clk);
      #1;
      if (done) kdone = k;
      @(negedge clk);
    end
    chk(kdone == klast, {"R4 R5 done edge ", tag}, kdone, klast);
    chk(!busy, {"R5 busy low ", tag}, busy, 0);
    for (int j = 0; j < 3; j++) begin
      hit = ~hit; din = DW'($urandom);
      @(negedge clk);
    end
    hit = 0;
    chk(done, {"R6 done held ", tag}, done, 1);
    for (int i = 0; i < szc; i++) begin
      rd_idx = AW'(i);
      #1;
      chk(rd_data == hist[ka - prec + i], {"R7 R3 R6 readout ", tag},
          rd_data, hist[ka - prec + i]);
    end
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk(!busy && !done, "R1 reset flags", {busy, done}, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done, "R1 after reset", {busy, done}, 0);

    capture(8, 3, 10, "basic");
    capture(8, 5, 1, "R4 early hit");
    capture(6, 0, 2, "no pre");
    capture(0, 0, 3, "R8 size zero");
    capture(31, 4, 6, "R8 size over depth");
    capture(5, 20, 1, "R9 pre over size");
    capture(16, 15, 2, "R9 full pre");
    capture(12, 6, 45, "R10 wrapped");
    capture(16, 8, 60, "R10 wrapped full");

    for (int n = 0; n < 25; n++)
      capture(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
              int'($urandom_range(1, 60)), "random");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule